// File: doc/BRIEF.md
# Composite Video Timing Reset Controller

This block owns the standard-definition line, pixel and field counters of a composite video timing generator and decides when the subcarrier phase accumulator is cleared. An external asynchronous pin carries reset requests. A 2-bit mode input chooses what a rising edge on that pin does. In timing-restart mode the counters are frozen and then restart at the first field. In phase-only mode the subcarrier phase clear waits for the next field boundary, and the counters keep running. In the disabled and lock modes the pin has no effect on this block.

A second, independent pair of pixel and line counters serves the high-definition timing path. A hold bit freezes these at zero without touching the standard-definition side. All counter values, the field index and a one-cycle phase-clear strobe are registered outputs. The subcarrier accumulator, the colour encoder and the DAC path are downstream consumers.

Top module: `vid_timing_reset_ctrl`

## Requirements
- R1: While `rst` is high, every output (`sd_h`, `sd_v`, `sd_field`, `phase_clr`, `hd_h`, `hd_v`) is zero.
- R2: `sd_h` counts 0 to SD_H_TOTAL-1, one step per clock, and wraps to 0. `sd_v` advances by one when `sd_h` wraps and returns to 0 after SD_V_LINES lines.
- R3: `sd_field` holds a 0-based field index, where 0 is Field 1. It changes only at the end of the last pixel of the last line. After index 3 it wraps to 0 when `pal_sel`=0. After index 7 it wraps to 0 when `pal_sel`=1.
- R4: `ext_pin` passes through a two-flop synchroniser, and actions fire on the rising edge of the synchronised level. A pulse that is high for a single clock is still recognised.
- R5: With `mode_sel`=2'b10 (timing restart), a rising edge freezes `sd_h`, `sd_v` and `sd_field` at 0 for as long as the pin stays high.
- R6: In timing-restart mode, the first clock edge that sees the synchronised pin low ends the hold. That is the third edge after the pin falls. In the cycle after that edge, `phase_clr` is 1 with `sd_h`=0, `sd_v`=0 and `sd_field`=0, and counting then resumes.
- R7: With `mode_sel`=2'b01 (phase only), a rising edge arms a deferred clear. `phase_clr` pulses once in the cycle where `sd_h`=1 and `sd_v`=0 of the next field. The field counter is not reset.
- R8: With `mode_sel`=2'b00 (disabled) or 2'b11 (lock), pin activity produces no `phase_clr` and does not stop the standard-definition counters.
- R9: While `hd_hold` is 1, `hd_h` and `hd_v` are held at 0. They resume counting when `hd_hold` returns to 0. The standard-definition counters are unaffected.
- R10: `phase_clr` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | 00 off, 01 phase only, 10 timing restart, 11 lock |
| pal_sel | input | 1 | 1 selects the 8-field sequence, 0 selects 4 fields |
| ext_pin | input | 1 | Asynchronous reset/lock pin |
| hd_hold | input | 1 | Holds the high-definition counters at zero |
| sd_h | output | $clog2(SD_H_TOTAL) | Standard-definition pixel count |
| sd_v | output | $clog2(SD_V_LINES) | Standard-definition line count within the field |
| sd_field | output | 3 | Field index, 0 = Field 1 |
| phase_clr | output | 1 | One-cycle subcarrier phase clear strobe |
| hd_h | output | $clog2(HD_H_TOTAL) | High-definition pixel count |
| hd_v | output | $clog2(HD_V_LINES) | High-definition line count |

## Verification
A pin change reaches the control logic two edges later, and a registered action appears one edge after that. The timing-restart strobe is therefore sampled on the third falling clock after the pin is released. The deferred phase clear is expected in the second pixel of the following field, so each expected strobe is queued with the pixel, line and field values that must accompany it. A monitor on the falling clock edge pops one entry for every strobe it sees. Counter and hold checks are sampled one full cycle after the stimulus that controls them.

// File: rtl/vtr_pkg.sv
package vtr_pkg;
  typedef enum logic [1:0] {
    VTR_OFF     = 2'b00,
    VTR_PHASE   = 2'b01,
    VTR_RESTART = 2'b10,
    VTR_LOCK    = 2'b11
  } vtr_mode_e;
endpackage

// File: rtl/vtr_pin_sync.sv
module vtr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prev <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/vtr_hv_counter.sv
module vtr_hv_counter #(
  parameter  int H_TOTAL = 858,
  parameter  int V_TOTAL = 262,
  localparam int HW      = $clog2(H_TOTAL),
  localparam int VW      = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  output logic [HW-1:0] h,
  output logic [VW-1:0] v
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      h <= '0;
      v <= '0;
    end else if (h == H_LAST) begin
      h <= '0;
      v <= (v == V_LAST) ? '0 : v + 1'b1;
    end else begin
      h <= h + 1'b1;
    end
  end
endmodule

// File: rtl/vtr_field_counter.sv
module vtr_field_counter #(
  parameter  int SHORT_SEQ = 4,
  parameter  int LONG_SEQ  = 8,
  localparam int FW        = $clog2(LONG_SEQ)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  input  logic          long_seq,
  output logic [FW-1:0] field
);
  localparam logic [FW-1:0] SHORT_LAST = FW'(SHORT_SEQ - 1);
  localparam logic [FW-1:0] LONG_LAST  = FW'(LONG_SEQ - 1);

  logic [FW-1:0] last;
  assign last = long_seq ? LONG_LAST : SHORT_LAST;

  always_ff @(posedge clk) begin
    if (rst || clr)  field <= '0;
    else if (adv)    field <= (field >= last) ? '0 : field + 1'b1;
  end
endmodule

// File: rtl/vid_timing_reset_ctrl.sv
module vid_timing_reset_ctrl
  import vtr_pkg::*;
#(
  parameter  int SD_H_TOTAL  = 858,
  parameter  int SD_V_LINES  = 262,
  parameter  int HD_H_TOTAL  = 2200,
  parameter  int HD_V_LINES  = 1125,
  parameter  int SYNC_STAGES = 2,
  localparam int SD_HW = $clog2(SD_H_TOTAL),
  localparam int SD_VW = $clog2(SD_V_LINES),
  localparam int HD_HW = $clog2(HD_H_TOTAL),
  localparam int HD_VW = $clog2(HD_V_LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_sel,
  input  logic             pal_sel,
  input  logic             ext_pin,
  input  logic             hd_hold,
  output logic [SD_HW-1:0] sd_h,
  output logic [SD_VW-1:0] sd_v,
  output logic [2:0]       sd_field,
  output logic             phase_clr,
  output logic [HD_HW-1:0] hd_h,
  output logic [HD_VW-1:0] hd_v
);
  localparam logic [SD_HW-1:0] SD_H_LAST = SD_HW'(SD_H_TOTAL - 1);
  localparam logic [SD_VW-1:0] SD_V_LAST = SD_VW'(SD_V_LINES - 1);

  vtr_mode_e mode;
  logic      pin_lvl, pin_rise;
  logic      tr_active, clr_pending;
  logic      sd_eof, sd_sof;

  assign mode = vtr_mode_e'(mode_sel);

  vtr_pin_sync #(.STAGES(SYNC_STAGES)) pin_sync_i (
    .clk(clk), .rst(rst), .din(ext_pin), .level(pin_lvl), .rise(pin_rise)
  );

  vtr_hv_counter #(.H_TOTAL(SD_H_TOTAL), .V_TOTAL(SD_V_LINES)) sd_cnt_i (
    .clk(clk), .rst(rst), .clr(tr_active), .h(sd_h), .v(sd_v)
  );

  assign sd_eof = (sd_h == SD_H_LAST) && (sd_v == SD_V_LAST);
  assign sd_sof = (sd_h == '0) && (sd_v == '0);

  vtr_field_counter #(.SHORT_SEQ(4), .LONG_SEQ(8)) field_i (
    .clk(clk), .rst(rst), .clr(tr_active), .adv(sd_eof),
    .long_seq(pal_sel), .field(sd_field)
  );

  vtr_hv_counter #(.H_TOTAL(HD_H_TOTAL), .V_TOTAL(HD_V_LINES)) hd_cnt_i (
    .clk(clk), .rst(rst), .clr(hd_hold), .h(hd_h), .v(hd_v)
  );

  // Restart hold has priority; a deferred clear is dropped by a restart.
  always_ff @(posedge clk) begin
    if (rst) begin
      tr_active   <= 1'b0;
      clr_pending <= 1'b0;
      phase_clr   <= 1'b0;
    end else begin
      phase_clr <= 1'b0;
      if (tr_active) begin
        if (!pin_lvl) begin
          tr_active   <= 1'b0;
          clr_pending <= 1'b0;
          phase_clr   <= 1'b1;
        end
      end else if (pin_rise && mode == VTR_RESTART) begin
        tr_active <= 1'b1;
      end else begin
        if (clr_pending && sd_sof) begin
          phase_clr   <= 1'b1;
          clr_pending <= 1'b0;
        end
        if (pin_rise && mode == VTR_PHASE) clr_pending <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vtr_checker.sv
module vtr_checker #(
  parameter int SD_H_TOTAL = 858,
  parameter int SD_V_LINES = 262,
  parameter int SD_HW = 10,
  parameter int SD_VW = 9,
  parameter int HD_HW = 12,
  parameter int HD_VW = 11
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode_sel,
  input logic             pin_rise,
  input logic             tr_active,
  input logic             phase_clr,
  input logic [SD_HW-1:0] sd_h,
  input logic [SD_VW-1:0] sd_v,
  input logic [2:0]       sd_field,
  input logic             hd_hold,
  input logic [HD_HW-1:0] hd_h,
  input logic [HD_VW-1:0] hd_v
);
  assert_h_range_R2: assert property (@(posedge clk) disable iff (rst)
    int'(sd_h) < SD_H_TOTAL);

  assert_h_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (!tr_active && int'(sd_h) != SD_H_TOTAL - 1) |=> sd_h == $past(sd_h) + 1'b1);

  assert_field_steady_R3: assert property (@(posedge clk) disable iff (rst)
    (!tr_active && !(int'(sd_h) == SD_H_TOTAL - 1 && int'(sd_v) == SD_V_LINES - 1))
      |=> $stable(sd_field));

  assert_hold_clears_R5: assert property (@(posedge clk) disable iff (rst)
    tr_active |=> (sd_h == '0 && sd_v == '0 && sd_field == '0));

  assert_inactive_modes_R8: assert property (@(posedge clk) disable iff (rst)
    (!tr_active && pin_rise && mode_sel != 2'b10) |=> !tr_active);

  assert_hd_hold_R9: assert property (@(posedge clk) disable iff (rst)
    hd_hold |=> (hd_h == '0 && hd_v == '0));

  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (rst)
    phase_clr |=> !phase_clr);
endmodule

bind vid_timing_reset_ctrl vtr_checker #(
  .SD_H_TOTAL(SD_H_TOTAL), .SD_V_LINES(SD_V_LINES),
  .SD_HW(SD_HW), .SD_VW(SD_VW), .HD_HW(HD_HW), .HD_VW(HD_VW)
) chk_i (
  .clk(clk), .rst(rst), .mode_sel(mode_sel), .pin_rise(pin_rise),
  .tr_active(tr_active), .phase_clr(phase_clr), .sd_h(sd_h), .sd_v(sd_v),
  .sd_field(sd_field), .hd_hold(hd_hold), .hd_h(hd_h), .hd_v(hd_v)
);

// File: tb/vid_timing_reset_ctrl_tb.sv
module vid_timing_reset_ctrl_tb_top;
  localparam int H = 8, V = 4, HDH = 6, HDV = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic       pal_sel = 1'b0, ext_pin = 1'b0, hd_hold = 1'b0;
  logic [2:0] sd_h;
  logic [1:0] sd_v;
  logic [2:0] sd_field;
  logic       phase_clr;
  logic [2:0] hd_h;
  logic [1:0] hd_v;

  always #10 clk = ~clk;

  vid_timing_reset_ctrl #(
    .SD_H_TOTAL(H), .SD_V_LINES(V), .HD_H_TOTAL(HDH), .HD_V_LINES(HDV)
  ) dut_i (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .pal_sel(pal_sel),
    .ext_pin(ext_pin), .hd_hold(hd_hold), .sd_h(sd_h), .sd_v(sd_v),
    .sd_field(sd_field), .phase_clr(phase_clr), .hd_h(hd_h), .hd_v(hd_v)
  );

  typedef struct { int h; int v; int f; string req; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  logic prev_clr = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: every strobe must match the next queued expectation.
  always @(negedge clk) begin
    if (!rst) begin
      if (phase_clr && prev_clr)
        chk(0, "R10", "strobe longer than one cycle", 2, 1);
      if (phase_clr) begin
        if (q.size() == 0) begin
          chk(0, "R8", "unexpected phase_clr", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(int'(sd_h) == e.h, e.req, "sd_h at strobe", int'(sd_h), e.h);
          chk(int'(sd_v) == e.v, e.req, "sd_v at strobe", int'(sd_v), e.v);
          chk(int'(sd_field) == e.f, e.req, "sd_field at strobe", int'(sd_field), e.f);
        end
      end
    end
    prev_clr = phase_clr;
  end

  task automatic push(input int h, input int v, input int f, input string req);
    exp_t e;
    e.h = h; e.v = v; e.f = f; e.req = req;
    q.push_back(e);
  endtask

  task automatic wait_for(input int h, input int v, input int f, input string req);
    for (int n = 0; n < 4000; n++) begin
      if (int'(sd_h) == h && int'(sd_v) == v && (f < 0 || int'(sd_field) == f)) return;
      @(negedge clk);
    end
    chk(0, req, "position never reached", int'(sd_h), h);
  endtask

  task automatic pulse(input int n);
    ext_pin = 1'b1;
    repeat (n) @(negedge clk);
    ext_pin = 1'b0;
  endtask

  task automatic no_effect(input logic [1:0] m, input string req);
    int h0;
    mode_sel = m;
    @(negedge clk);
    pulse(3);
    repeat (4) @(negedge clk);
    h0 = int'(sd_h);
    @(negedge clk);
    chk(int'(sd_h) == (h0 + 1) % H, req, "sd_h keeps counting", int'(sd_h), (h0 + 1) % H);
    repeat (3 * H * V) @(negedge clk);
    chk(q.size() == 0, req, "queue state", q.size(), 0);
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int f0, hd0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sd_h == 0 && sd_v == 0, "R1", "sd counters in reset", int'(sd_h), 0);
    chk(sd_field == 0 && phase_clr == 0, "R1", "field/strobe in reset", int'(sd_field), 0);
    chk(hd_h == 0 && hd_v == 0, "R1", "hd counters in reset", int'(hd_h), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(sd_h == 1 && sd_v == 0, "R2", "first step", int'(sd_h), 1);
    repeat (7) @(negedge clk);
    chk(sd_h == 0 && sd_v == 1, "R2", "line advance", int'(sd_v), 1);

    // R3: 4-field and 8-field sequences
    wait_for(H - 1, V - 1, 3, "R3");
    @(negedge clk);
    chk(sd_field == 0, "R3", "4-field wrap", int'(sd_field), 0);
    wait_for(H - 1, V - 1, 0, "R3");
    @(negedge clk);
    chk(sd_field == 1, "R3", "field advance", int'(sd_field), 1);
    pal_sel = 1'b1;
    wait_for(H - 1, V - 1, 3, "R3");
    @(negedge clk);
    chk(sd_field == 4, "R3", "8-field continues", int'(sd_field), 4);
    wait_for(H - 1, V - 1, 7, "R3");
    @(negedge clk);
    chk(sd_field == 0, "R3", "8-field wrap", int'(sd_field), 0);

    // R8: disabled and lock modes
    no_effect(2'b00, "R8");
    no_effect(2'b11, "R8");

    // R5 / R6: timing restart
    mode_sel = 2'b10;
    wait_for(5, 2, -1, "R5");
    ext_pin = 1'b1;
    repeat (10) @(negedge clk);
    chk(sd_h == 0 && sd_v == 0, "R5", "counters held", int'(sd_h), 0);
    chk(sd_field == 0, "R5", "field held at Field 1", int'(sd_field), 0);
    repeat (3) @(negedge clk);
    chk(sd_h == 0, "R5", "still held", int'(sd_h), 0);
    push(0, 0, 0, "R6");
    ext_pin = 1'b0;
    repeat (2) @(negedge clk);
    chk(phase_clr == 0 && sd_h == 0, "R6", "hold until sync low", int'(phase_clr), 0);
    @(negedge clk);
    chk(phase_clr == 1, "R6", "strobe on third cycle", int'(phase_clr), 1);
    @(negedge clk);
    chk(sd_h == 1, "R6", "counting resumes", int'(sd_h), 1);

    // R4: single-cycle pulse recognised
    wait_for(3, 1, -1, "R4");
    push(0, 0, 0, "R4");
    pulse(1);
    repeat (6) @(negedge clk);
    chk(q.size() == 0, "R4", "one-cycle pulse strobe", q.size(), 0);

    // R7: deferred phase clear, field keeps running
    mode_sel = 2'b01;
    wait_for(4, 1, 5, "R7");
    push(1, 0, 6, "R7");
    pulse(2);
    repeat (3 * H * V) @(negedge clk);
    chk(q.size() == 0, "R7", "PAL deferred strobe", q.size(), 0);
    pal_sel = 1'b0;
    wait_for(4, 1, 3, "R7");
    push(1, 0, 0, "R7");
    pulse(2);
    repeat (3 * H * V) @(negedge clk);
    chk(q.size() == 0, "R7", "NTSC wrap strobe", q.size(), 0);
    wait_for(4, 2, 1, "R7");
    f0 = int'(sd_field);
    push(1, 0, (f0 + 1) % 4, "R7");
    pulse(1);
    repeat (3 * H * V) @(negedge clk);
    chk(q.size() == 0, "R7", "second deferred strobe", q.size(), 0);

    // R9: HD hold
    hd_hold = 1'b1;
    repeat (5) @(negedge clk);
    chk(hd_h == 0 && hd_v == 0, "R9", "hd held", int'(hd_h), 0);
    hd0 = int'(sd_h);
    @(negedge clk);
    chk(int'(sd_h) == (hd0 + 1) % H, "R9", "sd unaffected", int'(sd_h), (hd0 + 1) % H);
    hd_hold = 1'b0;
    @(negedge clk);
    chk(hd_h == 1, "R9", "hd resumes", int'(hd_h), 1);

    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R10", "no leftover expectations", q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule